// File: doc/BRIEF.md
# Shared RAM Address Decoder with Guarded Debug Window

This block sits between a request bus and one 512KB on-chip RAM array. Requests are 32-bit words with per-byte write enables. Addresses span a 1MB byte space. The bottom 496KB always decodes straight onto the array. The top 16KB of the array is a reserved window for debug and boot code. That window answers at two byte addresses: its home copy occupies the last 16KB below 1MB, and an alias copy occupies the 16KB just below 512KB. Both copies select the same physical words and follow the same write rules.

A debug-enable input selects the mode. While it is high, the window is write-guarded on both copies: a guarded write never reaches the array and raises a one-cycle violation flag, while reads stay open. A privileged debugger input lifts the guard so that the window can be loaded. While debug-enable is low, the window is plain RAM, so bytes 0 to 512KB form one contiguous memory. Every other address between 512KB and the home copy is unmapped: a write there is discarded, a read there returns zero, and either raises a one-cycle map-error flag.

The RAM strobe, word address, byte enables and write data are registered, so they appear one cycle after the request. The RAM returns read data one cycle after its strobe, which places read responses two cycles after the request.

Top module: `hubRamDecoder`

## Requirements
- R1: While rstN is low, ramEn, ramWe, rdValid, protErr and mapErr are all 0.
- R2: A request to a byte address below 0x7C000 drives ramEn high in the following cycle, with ramAddr equal to address bits [18:2] and with the request's ramWe, ramBe and enabled write-data bytes. This holds in every mode.
- R3: A request to a byte address in 0xFC000..0xFFFFF (home copy) and one to the same offset in 0x7C000..0x7FFFF (alias copy) both drive ramAddr to address bits [18:2], so both reach the same word.
- R4: When debugEn=1 and debugPriv=0, a write to either copy leaves ramEn low in the following cycle and sets protErr for exactly that one cycle.
- R5: When debugEn=1, a read of either copy is never guarded: it strobes the RAM and returns the stored word.
- R6: When debugEn=1 and debugPriv=1, a write to either copy reaches the RAM and protErr stays 0.
- R7: When debugEn=0, writes to the alias copy and the home copy reach the RAM with protErr 0, so the range 0..0x7FFFF is contiguous ordinary RAM.
- R8: A request to a byte address in 0x80000..0xFBFFF leaves ramEn low and sets mapErr for one cycle, in the cycle after the request. A read there yields rdValid with rdData equal to zero two cycles after the request.
- R9: Every accepted read gives rdValid=1 for one cycle, two cycles after the request, and rdData carries the word the RAM returns.
- R10: A write below 0x7C000 never sets protErr, whatever the values of debugEn and debugPriv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| debugEn | input | 1 | 1: reserved window guarded; 0: whole array plain RAM |
| debugPriv | input | 1 | Debugger privilege, lifts the write guard |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | 20 | Byte address, bits [1:0] ignored |
| reqBe | input | 4 | Byte enables for writes |
| reqWdata | input | 32 | Write data |
| ramEn | output | 1 | RAM access strobe |
| ramWe | output | 1 | RAM write strobe |
| ramAddr | output | 17 | RAM word address |
| ramBe | output | 4 | RAM byte enables |
| ramWdata | output | 32 | RAM write data |
| ramRdata | input | 32 | RAM read data, valid one cycle after a read strobe |
| rdValid | output | 1 | Read response valid |
| rdData | output | 32 | Read response data |
| protErr | output | 1 | Guarded write was dropped |
| mapErr | output | 1 | Unmapped address was accessed |

## Verification
The read-return path and the write-guard path can be active in the same cycle. When a read is followed at once by a guarded write, rdValid for the read rises in the same cycle that protErr reports the dropped write, and an unmapped access can overlap either of them the same way. The bench sends back-to-back reads, guarded writes and unmapped accesses, including a hole read placed between two window writes. Each cycle it checks the strobe, both flags and the response against separate expected queues, so any leakage between the overlapping events appears as a mismatch.

// File: rtl/hubDecPkg.sv
package hubDecPkg;
  localparam int unsigned HUB_ADDR_W   = 20;
  localparam int unsigned HUB_RAM_LOG2 = 19;
  localparam int unsigned HUB_RSV_LOG2 = 14;
  localparam int unsigned HUB_DATA_W   = 32;

  typedef enum logic [1:0] {
    RGN_LOW,
    RGN_ALIAS,
    RGN_HOME,
    RGN_HOLE
  } region_e;

  typedef struct packed {
    logic ramEn;
    logic ramWe;
    logic rdTrack;
    logic rdZero;
  } ctrlStrobes_t;
endpackage

// File: rtl/hubDecCtrl.sv
module hubDecCtrl
  import hubDecPkg::*;
#(
  parameter int unsigned ADDR_W   = HUB_ADDR_W,
  parameter int unsigned RAM_LOG2 = HUB_RAM_LOG2,
  parameter int unsigned RSV_LOG2 = HUB_RSV_LOG2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [ADDR_W-1:RSV_LOG2]   addrHigh,
  input  logic                       debugEn,
  input  logic                       debugPriv,
  output ctrlStrobes_t               strobes,
  output logic                       protErr,
  output logic                       mapErr
);
  localparam int unsigned TAG_W = RAM_LOG2 - RSV_LOG2;
  localparam int unsigned HI_W  = ADDR_W - RAM_LOG2;

  logic [HI_W-1:0]  hiPart;
  logic [TAG_W-1:0] tagPart;
  region_e          region;
  logic             inWindow;
  logic             guarded;
  logic             blockWrite;
  logic             isHole;

  assign hiPart  = addrHigh[ADDR_W-1:RAM_LOG2];
  assign tagPart = addrHigh[RAM_LOG2-1:RSV_LOG2];

  // Region select: alias sits under the array top, home under the space top.
  always_comb begin
    if (hiPart == '0) begin
      region = (&tagPart) ? RGN_ALIAS : RGN_LOW;
    end else if ((&hiPart) && (&tagPart)) begin
      region = RGN_HOME;
    end else begin
      region = RGN_HOLE;
    end
  end

  assign inWindow   = (region == RGN_ALIAS) || (region == RGN_HOME);
  assign isHole     = (region == RGN_HOLE);
  assign guarded    = inWindow && debugEn && !debugPriv;
  assign blockWrite = reqWrite && guarded;

  always_comb begin
    strobes         = '0;
    strobes.ramEn   = reqValid && !isHole && !blockWrite;
    strobes.ramWe   = reqWrite;
    strobes.rdTrack = reqValid && !reqWrite;
    strobes.rdZero  = reqValid && !reqWrite && isHole;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protErr <= 1'b0;
      mapErr  <= 1'b0;
    end else begin
      protErr <= reqValid && blockWrite;
      mapErr  <= reqValid && isHole;
    end
  end
endmodule

// File: rtl/hubDecPath.sv
module hubDecPath
  import hubDecPkg::*;
#(
  parameter int unsigned DATA_W   = HUB_DATA_W,
  parameter int unsigned RAM_LOG2 = HUB_RAM_LOG2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobes_t                   strobes,
  input  logic [RAM_LOG2-1:$clog2(DATA_W/8)] wordAddr,
  input  logic [DATA_W/8-1:0]            reqBe,
  input  logic [DATA_W-1:0]              reqWdata,
  input  logic [DATA_W-1:0]              ramRdata,
  output logic                           ramEn,
  output logic                           ramWe,
  output logic [RAM_LOG2-$clog2(DATA_W/8)-1:0] ramAddr,
  output logic [DATA_W/8-1:0]            ramBe,
  output logic [DATA_W-1:0]              ramWdata,
  output logic                           rdValid,
  output logic [DATA_W-1:0]              rdData
);
  localparam int unsigned LANES = DATA_W / 8;

  logic rdTrackQ, rdZeroQ, rdPendQ, rdZero2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramEn   <= 1'b0;
      ramWe   <= 1'b0;
      ramAddr <= '0;
      ramBe   <= '0;
    end else begin
      ramEn <= strobes.ramEn;
      ramWe <= strobes.ramEn && strobes.ramWe;
      if (strobes.ramEn) begin
        ramAddr <= wordAddr;
        ramBe   <= strobes.ramWe ? reqBe : '0;
      end
    end
  end

  // Each data lane loads only when its byte is written.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ramWdata[lane*8 +: 8] <= '0;
      end else if (strobes.ramEn && strobes.ramWe && reqBe[lane]) begin
        ramWdata[lane*8 +: 8] <= reqWdata[lane*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdTrackQ <= 1'b0;
      rdZeroQ  <= 1'b0;
      rdPendQ  <= 1'b0;
      rdZero2Q <= 1'b0;
    end else begin
      rdTrackQ <= strobes.rdTrack;
      rdZeroQ  <= strobes.rdZero;
      rdPendQ  <= rdTrackQ;
      rdZero2Q <= rdZeroQ;
    end
  end

  assign rdValid = rdPendQ;
  assign rdData  = rdZero2Q ? '0 : ramRdata;
endmodule

// File: rtl/hubRamDecoder.sv
module hubRamDecoder
  import hubDecPkg::*;
#(
  parameter int unsigned ADDR_W   = HUB_ADDR_W,
  parameter int unsigned RAM_LOG2 = HUB_RAM_LOG2,
  parameter int unsigned RSV_LOG2 = HUB_RSV_LOG2,
  parameter int unsigned DATA_W   = HUB_DATA_W
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  debugEn,
  input  logic                                  debugPriv,
  input  logic                                  reqValid,
  input  logic                                  reqWrite,
  input  logic [ADDR_W-1:0]                     reqAddr,
  input  logic [DATA_W/8-1:0]                   reqBe,
  input  logic [DATA_W-1:0]                     reqWdata,
  output logic                                  ramEn,
  output logic                                  ramWe,
  output logic [RAM_LOG2-$clog2(DATA_W/8)-1:0]  ramAddr,
  output logic [DATA_W/8-1:0]                   ramBe,
  output logic [DATA_W-1:0]                     ramWdata,
  input  logic [DATA_W-1:0]                     ramRdata,
  output logic                                  rdValid,
  output logic [DATA_W-1:0]                     rdData,
  output logic                                  protErr,
  output logic                                  mapErr
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);

  ctrlStrobes_t strobes;
  logic         unusedAddrBits;

  assign unusedAddrBits = ^reqAddr[OFF_W-1:0];

  hubDecCtrl #(
    .ADDR_W  (ADDR_W),
    .RAM_LOG2(RAM_LOG2),
    .RSV_LOG2(RSV_LOG2)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .addrHigh (reqAddr[ADDR_W-1:RSV_LOG2]),
    .debugEn  (debugEn),
    .debugPriv(debugPriv),
    .strobes  (strobes),
    .protErr  (protErr),
    .mapErr   (mapErr)
  );

  hubDecPath #(
    .DATA_W  (DATA_W),
    .RAM_LOG2(RAM_LOG2)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wordAddr(reqAddr[RAM_LOG2-1:OFF_W]),
    .reqBe   (reqBe),
    .reqWdata(reqWdata),
    .ramRdata(ramRdata),
    .ramEn   (ramEn),
    .ramWe   (ramWe),
    .ramAddr (ramAddr),
    .ramBe   (ramBe),
    .ramWdata(ramWdata),
    .rdValid (rdValid),
    .rdData  (rdData)
  );
endmodule

// File: rtl/hubRamDecoderChk.sv
module hubRamDecoderChk #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned RAM_LOG2 = 19,
  parameter int unsigned RSV_LOG2 = 14,
  parameter int unsigned DATA_W   = 32
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 debugEn,
  input logic                                 debugPriv,
  input logic                                 reqValid,
  input logic                                 reqWrite,
  input logic [ADDR_W-1:0]                    reqAddr,
  input logic                                 ramEn,
  input logic                                 ramWe,
  input logic [RAM_LOG2-$clog2(DATA_W/8)-1:0] ramAddr,
  input logic                                 rdValid,
  input logic                                 protErr,
  input logic                                 mapErr
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);

  logic hiZero, hiTop, tagTop, holeReq, windowReq, lowReq;
  assign hiZero    = (reqAddr[ADDR_W-1:RAM_LOG2] == '0);
  assign hiTop     = &reqAddr[ADDR_W-1:RAM_LOG2];
  assign tagTop    = &reqAddr[RAM_LOG2-1:RSV_LOG2];
  assign holeReq   = !hiZero && !(hiTop && tagTop);
  assign windowReq = tagTop && !holeReq;
  assign lowReq    = hiZero && !tagTop;

  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!ramEn && !rdValid && !protErr && !mapErr); // R1
    end
  end

  AST_LOW_MAPS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && lowReq |=> ramEn && (ramAddr == $past(reqAddr[RAM_LOG2-1:OFF_W]))); // R2

  AST_WINDOW_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && windowReq && !reqWrite |=> ramEn && (ramAddr == $past(reqAddr[RAM_LOG2-1:OFF_W]))); // R3

  AST_GUARD_DROP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && windowReq && debugEn && !debugPriv |=> !ramEn && protErr); // R4

  AST_GUARD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    protErr |-> $past(reqValid && reqWrite && debugEn && !debugPriv)); // R4

  AST_PRIV_PASS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && windowReq && debugPriv |=> ramEn && ramWe && !protErr); // R6

  AST_OPEN_MODE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && windowReq && !debugEn |=> ramEn && ramWe && !protErr); // R7

  AST_HOLE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && holeReq |=> mapErr && !ramEn); // R8

  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(protErr && mapErr)); // R8

  AST_RD_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    ramEn && !ramWe |=> rdValid); // R9

  AST_LOW_NO_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && lowReq |=> !protErr); // R10
endmodule

bind hubRamDecoder hubRamDecoderChk #(
  .ADDR_W  (ADDR_W),
  .RAM_LOG2(RAM_LOG2),
  .RSV_LOG2(RSV_LOG2),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/tb_hubRamDecoder.sv
`timescale 1ns/100ps
module tb_hubRamDecoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        debugEn = 1'b0, debugPriv = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic        ramEn, ramWe, rdValid, protErr, mapErr;
  logic [16:0] ramAddr;
  logic [3:0]  ramBe;
  logic [31:0] ramWdata, rdData;
  logic [31:0] ramRdata = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  bit modeEn = 1, modePriv = 0;

  typedef struct {
    int cyc; bit en; bit we; logic [16:0] addr; logic [3:0] be;
    logic [31:0] wd; bit perr; bit merr; string tag;
  } stb_t;
  typedef struct { int cyc; logic [31:0] data; string tag; } rd_t;
  stb_t sq[$];
  rd_t  rq[$];
  logic [31:0] refMem [int];
  logic [31:0] ramMem [int];

  always #2.5 clk = ~clk;

  hubRamDecoder dut (.*);

  // RAM model: one cycle read latency
  always @(posedge clk) begin
    if (ramEn) begin
      if (ramWe) begin
        logic [31:0] w;
        w = ramMem.exists(int'(ramAddr)) ? ramMem[int'(ramAddr)] : 32'h0;
        for (int b = 0; b < 4; b++) if (ramBe[b]) w[b*8 +: 8] = ramWdata[b*8 +: 8];
        ramMem[int'(ramAddr)] = w;
      end else begin
        ramRdata <= ramMem.exists(int'(ramAddr)) ? ramMem[int'(ramAddr)] : 32'h0;
      end
    end
  end

  function automatic logic [31:0] bmask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  task automatic fail(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    errors++;
    $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
  endtask

  // Driver: expected results come from the address map in the requirements
  task automatic issue(input bit wr, input logic [19:0] a, input logic [3:0] be,
                       input logic [31:0] d, input string tag);
    bit hole, win, guard, pass;
    stb_t s; rd_t r; int w;
    hole  = !(a[19] == 1'b0 || a[19:14] == 6'h3F);
    win   = !hole && (a[18:14] == 5'h1F);
    guard = win && modeEn && !modePriv;
    pass  = !hole && !(wr && guard);
    w     = int'(a[18:2]);
    @(negedge clk);
    debugEn = modeEn; debugPriv = modePriv;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqBe = be; reqWdata = d;
    s.cyc = cyc + 1; s.en = pass; s.we = wr; s.addr = a[18:2]; s.be = be; s.wd = d;
    s.perr = wr && guard; s.merr = hole; s.tag = tag;
    sq.push_back(s);
    if (pass && wr) begin
      logic [31:0] v;
      v = refMem.exists(w) ? refMem[w] : 32'h0;
      refMem[w] = (v & ~bmask(be)) | (d & bmask(be));
    end
    if (!wr) begin
      r.cyc = cyc + 2; r.tag = tag;
      r.data = hole ? 32'h0 : (refMem.exists(w) ? refMem[w] : 32'h0);
      rq.push_back(r);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 0; reqWrite = 0;
    end
  endtask

  // Monitor: compare after each edge, away from it
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rstN) begin
      if (sq.size() != 0 && sq[0].cyc == cyc) begin
        stb_t s;
        s = sq.pop_front();
        checks++;
        if (ramEn !== s.en) fail(s.tag, "ramEn", 32'(ramEn), 32'(s.en));
        else if (s.en && ramAddr !== s.addr) fail(s.tag, "ramAddr", 32'(ramAddr), 32'(s.addr));
        else if (s.en && ramWe !== s.we) fail(s.tag, "ramWe", 32'(ramWe), 32'(s.we));
        else if (s.en && s.we && ramBe !== s.be) fail(s.tag, "ramBe", 32'(ramBe), 32'(s.be));
        else if (s.en && s.we && (ramWdata & bmask(s.be)) !== (s.wd & bmask(s.be)))
          fail(s.tag, "ramWdata", ramWdata & bmask(s.be), s.wd & bmask(s.be));
        if (protErr !== s.perr) fail(s.tag, "protErr", 32'(protErr), 32'(s.perr));
        if (mapErr !== s.merr) fail(s.tag, "mapErr", 32'(mapErr), 32'(s.merr));
      end else begin
        if (ramEn || protErr || mapErr) begin
          checks++;
          fail("R4", "idle-cycle strobe or flag", {29'h0, ramEn, protErr, mapErr}, 32'h0);
        end
      end
      if (rq.size() != 0 && rq[0].cyc == cyc) begin
        rd_t r;
        r = rq.pop_front();
        checks++;
        if (rdValid !== 1'b1) fail(r.tag, "rdValid", 32'(rdValid), 32'h1);
        else if (rdData !== r.data) fail(r.tag, "rdData", rdData, r.data);
      end else if (rdValid) begin
        checks++;
        fail("R9", "spurious rdValid", 32'h1, 32'h0);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R1: quiet outputs during reset
    if (ramEn || ramWe || rdValid || protErr || mapErr)
      fail("R1", "outputs in reset", {27'h0, ramEn, ramWe, rdValid, protErr, mapErr}, 32'h0);
    rstN = 1;
    idle(2);

    // R2 and R9: plain low-region traffic with full and partial byte enables
    modeEn = 1; modePriv = 0;
    issue(1, 20'h00100, 4'hF, 32'hA5A5_1234, "R2");
    issue(0, 20'h00100, 4'h0, 32'h0, "R9");
    issue(1, 20'h00104, 4'h3, 32'hDEAD_BEEF, "R2");
    issue(1, 20'h00104, 4'h8, 32'h7700_0000, "R2");
    issue(0, 20'h00104, 4'h0, 32'h0, "R9");
    idle(3);

    // R4: guarded writes to both copies are dropped
    issue(1, 20'h7C010, 4'hF, 32'h1111_1111, "R4");
    issue(1, 20'hFC010, 4'hF, 32'h2222_2222, "R4");
    issue(0, 20'h7C010, 4'h0, 32'h0, "R5");
    issue(1, 20'h7C000, 4'hF, 32'h3333_3333, "R4");
    issue(1, 20'hFFFFC, 4'hF, 32'h4444_4444, "R4");
    idle(3);

    // R6: privilege lifts the guard, R3 and R5: alias reads what home wrote
    modePriv = 1;
    issue(1, 20'hFC020, 4'hF, 32'hCAFE_F00D, "R6");
    issue(1, 20'h7FFFC, 4'hF, 32'h0BAD_CAFE, "R6");
    modePriv = 0;
    issue(0, 20'h7C020, 4'h0, 32'h0, "R3");
    issue(0, 20'hFFFFC, 4'h0, 32'h0, "R5");
    idle(3);

    // R8: unmapped hole, edge addresses on both sides of it
    issue(1, 20'h80000, 4'hF, 32'h5555_5555, "R8");
    issue(0, 20'hC0000, 4'h0, 32'h0, "R8");
    issue(0, 20'hFBFFC, 4'h0, 32'h0, "R8");
    issue(1, 20'h7BFFC, 4'hF, 32'h6666_6666, "R10");
    issue(0, 20'h7BFFC, 4'h0, 32'h0, "R2");
    idle(3);

    // R7: debug off, window is ordinary RAM on both copies
    modeEn = 0;
    issue(1, 20'h7C030, 4'hF, 32'h7777_0001, "R7");
    issue(0, 20'hFC030, 4'h0, 32'h0, "R3");
    issue(1, 20'hFC040, 4'h5, 32'h00AB_00CD, "R7");
    issue(0, 20'h7C040, 4'h0, 32'h0, "R7");
    issue(1, 20'h00200, 4'hF, 32'h8888_8888, "R10");
    idle(3);

    // Overlap: read return coincides with a guarded drop and a hole access
    modeEn = 1;
    for (int i = 0; i < 6; i++) begin
      issue(0, 20'h00100 + 20'(i * 4), 4'h0, 32'h0, "R9");
      issue(1, 20'hFC100 + 20'(i * 4), 4'hF, 32'(i), "R4");
      issue(0, 20'h90000 + 20'(i * 4), 4'h0, 32'h0, "R8");
      issue(1, 20'h7C100 + 20'(i * 4), 4'hF, 32'(i), "R4");
      issue(1, 20'h00300 + 20'(i * 4), 4'hF, 32'(i + 16), "R10");
    end
    modePriv = 1;
    issue(1, 20'h7C200, 4'hF, 32'h1234_5678, "R6");
    modePriv = 0;
    issue(0, 20'hFC200, 4'h0, 32'h0, "R5");
    idle(4);

    checks++;
    if (sq.size() != 0 || rq.size() != 0)
      fail("R9", "outstanding expectations", 32'(sq.size() + rq.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule